// File: doc/BRIEF.md
# Arithmetic Issue Stage with Shared Dispatch Port

This block is the issue stage of one processor sub-partition. A stream of decoded arithmetic instructions arrives over a valid/ready handshake, one per cycle at most. Each instruction carries a class code that names its execution pipe: single-precision fused multiply-add, paired half-precision (two 16-bit values packed in one 32-bit lane operand), matrix-multiply, or double precision. Instructions leave in program order. Nothing is reordered.

The multiply-add pipe has a dispatch port of its own. The half-precision, matrix and double-precision pipes share a second port. Each port accepts at most one instruction every two cycles. So a stream that alternates multiply-add with any shared-port class can issue every cycle. A stream that mixes only shared-port classes is capped at one instruction every two cycles.

Every pipe is fully pipelined and has a fixed latency. It raises a one-cycle completion strobe carrying the instruction's sequence number. Per-class issue counters and a cycle counter let a test compare the measured issue rate with the ceiling.

Top module: `disp_issue_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `in_ready` is 1 for every class, `done_vld` is 0, and every issue counter is 0.
- R2: Class codes are 0 = multiply-add, 1 = half-precision pair, 2 = matrix, 3 = double. If a class-0 instruction is accepted (`in_valid & in_ready`) in cycle n, `in_ready` for class 0 is 0 in cycle n+1 and 1 again in cycle n+2.
- R3: Classes 1, 2 and 3 share one port. An accept of any of them in cycle n makes `in_ready` 0 for all three in cycle n+1 and 1 in cycle n+2.
- R4: The two ports are independent. A stream alternating class 0 and class 1 is accepted on every cycle, which is an issue rate of 1.0.
- R5: `in_ready` depends only on the port of the class presented in that cycle. A busy shared port never stalls class 0, and a busy class-0 port never stalls classes 1 to 3.
- R6: An instruction of class c accepted in cycle n gives a one-cycle pulse on `done_vld[c]` in cycle n+L. L is 4 for classes 0, 1 and 3 and 8 for class 2 (default parameters).
- R7: The completion tag on field c (`done_tag[c*TAG_W +: TAG_W]`) is the sequence number of the instruction. The first instruction accepted after reset gets 0, and each later accept adds 1 modulo 2^TAG_W.
- R8: Pipes overlap work. Instructions accepted back to back into one pipe each produce their own strobe, spaced the same as their accepts.
- R9: `issue_cnt[c*CNT_W +: CNT_W]` counts accepts of class c. `cycle_cnt` rises by one per clock cycle outside reset.
- R10: A cycle with `in_valid` low dispatches nothing. No counter moves, no later strobe appears, and the port stays free.
- R11: Reset during flight discards every pending completion and restarts the sequence number at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present |
| in_cls | input | 2 | Class code of the presented instruction |
| in_ready | output | 1 | Port of the presented class can accept this cycle |
| done_vld | output | 4 | Completion strobe, one bit per class |
| done_tag | output | 4*TAG_W | Sequence number per class field |
| issue_cnt | output | 4*CNT_W | Accept count per class field |
| cycle_cnt | output | CNT_W | Cycles since reset |

## Verification
The bench goes after port coupling.

- It presents two shared-port classes one cycle apart. A design that gave each class a private port would wrongly accept the second one.
- It presents multiply-add right behind a half-precision accept. A design that used one port for all classes would stall it and halve the alternating rate.
- It drives a long alternating run past the tag width. Tags that failed to wrap, or strobes landing one cycle early or late, show up as mismatched completions.
- It drives back-to-back matrix accepts. A single-entry pipe would drop one of them.
- It resets while a matrix instruction is in flight. A stale strobe after reset exposes a pipe that ignores reset.

// File: rtl/disp_pkg.sv
package disp_pkg;

    localparam int NUM_PIPES = 4;

    typedef enum logic [1:0] {
        CLS_FMA  = 2'd0,
        CLS_HALF = 2'd1,
        CLS_MMA  = 2'd2,
        CLS_DBL  = 2'd3
    } cls_e;

endpackage

// File: rtl/disp_port_gate.sv
module disp_port_gate #(
    parameter int GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    output logic free
);
    localparam int CW = $clog2(GAP) + 1;

    typedef struct packed {
        logic [CW-1:0] wait_cnt;
    } gate_t;

    gate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.wait_cnt = CW'(GAP - 1);
        end else if (st_q.wait_cnt != '0) begin
            st_d.wait_cnt = st_q.wait_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign free = (st_q.wait_cnt == '0);

    AST_TAKE_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> free); // R3

    generate
        if (GAP > 1) begin : g_gap
            AST_PORT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                take |=> !free); // R2
        end
    endgenerate

endmodule

// File: rtl/disp_exec_pipe.sv
module disp_exec_pipe #(
    parameter int LAT   = 4,
    parameter int TAG_W = 6,
    parameter int GAP   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TAG_W-1:0] load_tag,
    output logic             done,
    output logic [TAG_W-1:0] done_tag
);
    localparam int MAX_FLIGHT = (LAT + GAP - 1) / GAP;

    typedef struct packed {
        logic [LAT-1:0]            vld;
        logic [LAT-1:0][TAG_W-1:0] tag;
    } pipe_t;

    pipe_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < LAT; i++) begin
            if (i == 0) begin
                st_d.vld[0] = load;
                st_d.tag[0] = load_tag;
            end else begin
                st_d.vld[i] = st_q.vld[i-1];
                st_d.tag[i] = st_q.tag[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done     = st_q.vld[LAT-1];
    assign done_tag = st_q.tag[LAT-1];

    AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.vld) <= MAX_FLIGHT); // R8

endmodule

// File: rtl/disp_issue_unit.sv
module disp_issue_unit
    import disp_pkg::*;
#(
    parameter int TAG_W    = 6,
    parameter int CNT_W    = 16,
    parameter int GAP      = 2,
    parameter int LAT_FMA  = 4,
    parameter int LAT_HALF = 4,
    parameter int LAT_MMA  = 8,
    parameter int LAT_DBL  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [1:0]                 in_cls,
    output logic                       in_ready,
    output logic [NUM_PIPES-1:0]       done_vld,
    output logic [NUM_PIPES*TAG_W-1:0] done_tag,
    output logic [NUM_PIPES*CNT_W-1:0] issue_cnt,
    output logic [CNT_W-1:0]           cycle_cnt
);
    localparam int LATS [NUM_PIPES] = '{LAT_FMA, LAT_HALF, LAT_MMA, LAT_DBL};

    typedef struct packed {
        logic [TAG_W-1:0]                seq;
        logic [NUM_PIPES-1:0][CNT_W-1:0] icnt;
        logic [CNT_W-1:0]                cyc;
    } top_t;

    top_t st_d, st_q;

    cls_e                 cls;
    logic                 fma_free, shr_free;
    logic                 accept;
    logic [NUM_PIPES-1:0] dispatch;

    assign cls      = cls_e'(in_cls);
    assign in_ready = (cls == CLS_FMA) ? fma_free : shr_free;
    assign accept   = in_valid & in_ready;

    generate
        for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
            assign dispatch[p] = accept && (in_cls == p[1:0]);

            disp_exec_pipe #(
                .LAT   (LATS[p]),
                .TAG_W (TAG_W),
                .GAP   (GAP)
            ) u_pipe (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (dispatch[p]),
                .load_tag (st_q.seq),
                .done     (done_vld[p]),
                .done_tag (done_tag[p*TAG_W +: TAG_W])
            );

            assign issue_cnt[p*CNT_W +: CNT_W] = st_q.icnt[p];

            AST_DONE_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
                done_vld[p] |-> (st_q.icnt[p] != '0)); // R6
        end
    endgenerate

    disp_port_gate #(.GAP(GAP)) u_gate_fma (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (dispatch[CLS_FMA]),
        .free  (fma_free)
    );

    disp_port_gate #(.GAP(GAP)) u_gate_shared (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (dispatch[CLS_HALF] | dispatch[CLS_MMA] | dispatch[CLS_DBL]),
        .free  (shr_free)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cyc = st_q.cyc + 1'b1;
        if (accept) begin
            st_d.seq = st_q.seq + 1'b1;
        end
        for (int p = 0; p < NUM_PIPES; p++) begin
            if (dispatch[p]) st_d.icnt[p] = st_q.icnt[p] + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cycle_cnt = st_q.cyc;

    AST_ONE_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dispatch)); // R3

    AST_IDLE_NO_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (dispatch == '0)); // R10

endmodule

// File: tb/sim_disp_issue_unit.sv
`timescale 1ns/1ps
module sim_disp_issue_unit;
    localparam int TW = 6;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    in_cls = 2'd0;
    logic          in_ready;
    logic [3:0]    done_vld;
    logic [4*TW-1:0] done_tag;
    logic [4*CW-1:0] issue_cnt;
    logic [CW-1:0]   cycle_cnt;

    always #2 clk = ~clk;

    disp_issue_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
        .in_ready(in_ready), .done_vld(done_vld), .done_tag(done_tag),
        .issue_cnt(issue_cnt), .cycle_cnt(cycle_cnt)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [TW-1:0] seq = '0;
    int icnt [4];
    logic          ev [4][16];
    logic [TW-1:0] et [4][16];

    function automatic int lat_of(input int c);
        return (c == 2) ? 8 : 4;
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic clear_model();
        seq = '0;
        for (int p = 0; p < 4; p++) begin
            icnt[p] = 0;
            for (int s = 0; s < 16; s++) begin ev[p][s] = 1'b0; et[p][s] = '0; end
        end
    endtask

    // One cycle: drive, check completions (R6 R7 R8), optionally ready, then clock.
    task automatic step(input logic v, input logic [1:0] c, input logic chk_rdy,
                        input logic exp_rdy, input string req);
        int slot;
        @(negedge clk);
        in_valid = v;
        in_cls   = c;
        #1;
        slot = cyc % 16;
        for (int p = 0; p < 4; p++) begin
            chk(done_vld[p] == ev[p][slot], "R6 done strobe", int'(done_vld[p]), int'(ev[p][slot]));
            if (ev[p][slot])
                chk(done_tag[p*TW +: TW] == et[p][slot], "R7 tag",
                    int'(done_tag[p*TW +: TW]), int'(et[p][slot]));
            ev[p][slot] = 1'b0;
        end
        if (chk_rdy) chk(in_ready == exp_rdy, req, int'(in_ready), int'(exp_rdy));
        if (v && in_ready) begin
            ev[c][(cyc + lat_of(int'(c))) % 16] = 1'b1;
            et[c][(cyc + lat_of(int'(c))) % 16] = seq;
            seq = seq + 1'b1;
            icnt[c]++;
        end
        @(posedge clk);
        cyc++;
    endtask

    // {valid, class, expected ready}
    localparam logic [3:0] VEC [34] = '{
        4'b1_00_1, 4'b1_00_0, 4'b1_00_1, 4'b1_01_1, 4'b1_00_1, 4'b1_10_1,
        4'b1_11_0, 4'b1_11_1, 4'b1_01_0, 4'b1_01_1, 4'b1_00_1, 4'b1_01_1,
        4'b1_00_1, 4'b1_01_1, 4'b1_00_1, 4'b1_01_1, 4'b1_00_1, 4'b1_01_1,
        4'b0_00_1, 4'b0_01_1, 4'b1_10_1, 4'b1_00_1, 4'b1_10_1, 4'b1_10_0,
        4'b1_10_1, 4'b0_00_1, 4'b0_00_1, 4'b0_00_1, 4'b0_00_1, 4'b0_00_1,
        4'b0_00_1, 4'b0_00_1, 4'b0_00_1, 4'b0_00_1
    };

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int c0, c1;
        clear_model();
        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 ready in reset", int'(in_ready), 1);
        chk(done_vld == 4'b0, "R1 done in reset", int'(done_vld), 0);
        chk(issue_cnt == '0, "R1 counters in reset", int'(issue_cnt[CW-1:0]), 0);
        rst_n = 1'b1;
        cyc = 0;

        // Table walk: R2 R3 R4 R5 R6 R8 R10
        foreach (VEC[i]) begin
            step(VEC[i][3], VEC[i][2:1], 1'b1, VEC[i][0], "R2 R3 R4 R5 ready pattern");
        end
        // R9 issue counters, R10 idle rows did not count
        for (int p = 0; p < 4; p++)
            chk(issue_cnt[p*CW +: CW] == CW'(icnt[p]), "R9 R10 issue count",
                int'(issue_cnt[p*CW +: CW]), icnt[p]);

        // R9 cycle counter
        @(negedge clk); #1; c0 = int'(cycle_cnt);
        @(posedge clk); cyc++;
        for (int k = 0; k < 9; k++) step(1'b0, 2'd0, 1'b0, 1'b0, "");
        @(negedge clk); #1; c1 = int'(cycle_cnt);
        chk(c1 - c0 == 10, "R9 cycle count", c1 - c0, 10);
        @(posedge clk); cyc++;

        // R4 R7 long alternation wrapping the tag, every cycle accepted
        for (int k = 0; k < 70; k++)
            step(1'b1, (k % 2 == 0) ? 2'd0 : 2'd1, 1'b1, 1'b1, "R4 alternating rate");
        for (int k = 0; k < 6; k++) step(1'b0, 2'd0, 1'b0, 1'b0, "");

        // R5 shared busy does not stall class 0, class 0 busy does not stall class 3
        step(1'b1, 2'd3, 1'b1, 1'b1, "R5 shared free");
        step(1'b1, 2'd0, 1'b1, 1'b1, "R5 fma while shared busy");
        step(1'b1, 2'd3, 1'b1, 1'b1, "R5 shared while fma busy");
        for (int k = 0; k < 6; k++) step(1'b0, 2'd0, 1'b0, 1'b0, "");

        // R11 reset with a matrix instruction in flight
        step(1'b1, 2'd2, 1'b1, 1'b1, "R11 accept before reset");
        step(1'b0, 2'd0, 1'b0, 1'b0, "");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        clear_model();
        chk(issue_cnt == '0, "R11 counters cleared", int'(issue_cnt[2*CW +: CW]), 0);
        for (int k = 0; k < 10; k++) step(1'b0, 2'd0, 1'b0, 1'b0, "");
        step(1'b1, 2'd1, 1'b1, 1'b1, "R11 ready after reset");
        for (int k = 0; k < 6; k++) step(1'b0, 2'd0, 1'b0, 1'b0, "");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule